// File: doc/BRIEF.md
# Three-Wire Register Bus Master

This block is the hardware side of a serial control link made of three lines: a clock, a bidirectional data line and a read/write-select line. A client starts a single-register write or read with a one-cycle start pulse that carries a 5-bit logical address, an 8-bit value and a direction flag. The master runs the whole bus sequence and answers with a one-cycle done pulse. For reads it also returns the byte it collected from the data line.

The attached device splits its registers into two banks of sixteen. Logical addresses 0x10 to 0x1F reach the second bank, and the lower sixteen reach the first. The master remembers which bank the device has selected. When a request targets the other bank, it first sends a write to the bank-select register by itself. Three registers take a value that differs from the one the client wants. The master converts these on the way out, so the client always works with logical values.

The data line is split into an output, an output-enable and an input, and the pad ring combines them. One delay unit lasts `UNIT_CYCLES` system clocks.

Top module: `tw_bus_master`

## Requirements
- R1: After reset the bus rests with bus_clk high, bus_rw low and bus_doe low, and busy and req_done are low.
- R2: A powered write opens a frame: bus_rw and bus_doe go high together while bus_clk stays high for one delay unit. Sixteen bit periods follow. In each one bus_clk is low for one unit and then high for one unit, and bus_dout is valid across the rising clock edge. The 8-bit physical data goes out first, least significant bit first, then the physical address byte (zero-extended 4 bits). The frame then closes: bus_doe and bus_rw drop for one unit before req_done.
- R3: Logical addresses 0x10 and above select bank 2, with physical address = logical − 0x10. Lower addresses select bank 1. When the bank differs from the remembered one, a separate frame comes first that writes the bank number (1 or 2) as data to physical address 0x01, and the remembered bank is updated.
- R4: An access to the bank already remembered sends no bank-select frame.
- R5: A write to logical address 0x03 sends 255 minus the logical value.
- R6: A write to logical address 0x09 sends 255 − v when v < 64, and otherwise (191 − v) modulo 256.
- R7: A write to logical address 0x12 sends the logical value with bits 4, 1 and 0 forced to 1.
- R8: Writes to all other addresses send the value unchanged.
- R9: A powered read sends a frame that holds only the address byte (8 bit periods) and closes it. It then runs 8 more clock periods with bus_doe low. It samples bus_din at the end of each low phase, builds the byte least significant bit first, and presents it on req_rdata while req_done is high.
- R10: While powered is low, a request makes no bus activity. req_done arrives in the cycle after the start, and a read returns 0.
- R11: Each rising edge of powered clears the remembered bank, so the next powered access always sends a bank-select frame.
- R12: busy is high from the cycle after an accepted start up to and including the done cycle. A start pulse while busy is ignored and produces no frame and no done.
- R13: req_done is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| powered | input | 1 | Bus interface powered; low suppresses all bus activity |
| req_start | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Logical register address |
| req_wdata | input | 8 | Logical write value |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read result, valid with req_done |
| busy | output | 1 | Request in progress |
| bus_clk | output | 1 | Serial bus clock |
| bus_rw | output | 1 | Read/write-select line, high during a driven frame |
| bus_dout | output | 1 | Data line output value |
| bus_doe | output | 1 | Data line output enable |
| bus_din | input | 1 | Data line input value |

## Verification
A slave model rebuilds every frame from the bus lines and compares it with a queue of frames predicted from the requirements. A master that skipped the bank-select frame, or sent one at the wrong time, would put an unexpected frame on the bus or leave one in the queue. This covers switches after a bank change and after power returns, even though the bank is the same. The capacitor register is tested below 64, at 64 and above 191, where the subtraction wraps. A wrong split point or wrap would show up as a bad data byte. Reads return a byte whose bits are not symmetric, so a reversed bit order or a sample taken at the wrong edge changes the result. A repeated start during a transfer, and requests made while unpowered, must leave the bus silent; a master that accepted them would send extra frames or extra done pulses.

// File: rtl/twb_pkg.sv
package twb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_TX_LO, ST_TX_HI, ST_FIN, ST_RX_LO, ST_RX_HI, ST_DONE
    } twb_state_e;

    localparam logic [3:0] BANK_SEL_PADDR = 4'h1;
    localparam logic [4:0] OSC_LADDR      = 5'h03;
    localparam logic [4:0] CAP_LADDR      = 5'h09;
    localparam logic [4:0] CTRL_LADDR     = 5'h12;
    localparam logic [7:0] CTRL_ONES      = 8'h13;
    localparam logic [7:0] CAP_SPLIT      = 8'd64;
    localparam logic [7:0] CAP_LOW_BASE   = 8'd255;
    localparam logic [7:0] CAP_HIGH_BASE  = 8'd191;
endpackage

// File: rtl/twb_remap.sv
module twb_remap
    import twb_pkg::*;
(
    input  logic [4:0] laddr,
    input  logic [7:0] ldata,
    output logic [1:0] bank,
    output logic [3:0] paddr,
    output logic [7:0] pdata
);
    always_comb begin
        bank  = laddr[4] ? 2'd2 : 2'd1;
        paddr = laddr[3:0];
        unique case (laddr)
            OSC_LADDR:  pdata = 8'd255 - ldata;
            CAP_LADDR:  pdata = (ldata < CAP_SPLIT) ? (CAP_LOW_BASE - ldata)
                                                    : (CAP_HIGH_BASE - ldata);
            CTRL_LADDR: pdata = ldata | CTRL_ONES;
            default:    pdata = ldata;
        endcase
    end
endmodule

// File: rtl/twb_timer.sv
module twb_timer #(
    parameter int UNIT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(UNIT_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && (cnt_q == LAST);
        cnt_d  = (!run || expire) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: each delay unit restarts from zero after it expires
    assert_unit_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));
endmodule

// File: rtl/tw_bus_master.sv
module tw_bus_master
    import twb_pkg::*;
#(
    parameter int UNIT_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       powered,
    input  logic       req_start,
    input  logic       req_write,
    input  logic [4:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       req_done,
    output logic [7:0] req_rdata,
    output logic       busy,
    output logic       bus_clk,
    output logic       bus_rw,
    output logic       bus_dout,
    output logic       bus_doe,
    input  logic       bus_din
);
    typedef struct packed {
        twb_state_e  st;
        logic [1:0]  shadow;
        logic        pwr;
        logic        sw;
        logic        rd;
        logic        last;
        logic [2:0]  bitn;
        logic        bytn;
        logic [15:0] sh;
        logic [15:0] pay;
        logic [1:0]  bank;
        logic [7:0]  rx;
    } ctl_t;

    ctl_t q, d;
    logic unit_end, timer_run;
    logic [1:0] rq_bank;
    logic [3:0] rq_paddr;
    logic [7:0] rq_pdata;

    twb_remap u_remap (
        .laddr (req_addr),
        .ldata (req_wdata),
        .bank  (rq_bank),
        .paddr (rq_paddr),
        .pdata (rq_pdata)
    );

    assign timer_run = (q.st != ST_IDLE) && (q.st != ST_DONE);

    twb_timer #(.UNIT_CYCLES(UNIT_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (timer_run),
        .expire (unit_end)
    );

    always_comb begin
        d     = q;
        d.pwr = powered;
        unique case (q.st)
            ST_IDLE: if (req_start) begin
                d.rd   = !req_write;
                d.bank = rq_bank;
                d.rx   = '0;
                d.pay  = req_write ? {4'h0, rq_paddr, rq_pdata} : {8'h00, 4'h0, rq_paddr};
                if (!powered) begin
                    d.st = ST_DONE;
                end else begin
                    d.st = ST_SETUP;
                    d.sw = (rq_bank != q.shadow);
                    if (rq_bank != q.shadow) begin
                        d.sh   = {4'h0, BANK_SEL_PADDR, 6'h0, rq_bank};
                        d.last = 1'b1;
                    end else begin
                        d.sh   = req_write ? {4'h0, rq_paddr, rq_pdata} : {8'h00, 4'h0, rq_paddr};
                        d.last = req_write;
                    end
                end
            end
            ST_SETUP: if (unit_end) begin
                d.st   = ST_TX_LO;
                d.bitn = '0;
                d.bytn = 1'b0;
            end
            ST_TX_LO: if (unit_end) d.st = ST_TX_HI;
            ST_TX_HI: if (unit_end) begin
                d.sh = q.sh >> 1;
                d.st = ST_TX_LO;
                if (q.bitn == 3'd7) begin
                    d.bitn = '0;
                    if (q.bytn == q.last) d.st = ST_FIN;
                    else                  d.bytn = 1'b1;
                end else begin
                    d.bitn = q.bitn + 1'b1;
                end
            end
            ST_FIN: if (unit_end) begin
                if (q.sw) begin
                    d.shadow = q.bank;
                    d.sw     = 1'b0;
                    d.sh     = q.pay;
                    d.last   = !q.rd;
                    d.st     = ST_SETUP;
                end else if (q.rd) begin
                    d.st   = ST_RX_LO;
                    d.bitn = '0;
                end else begin
                    d.st = ST_DONE;
                end
            end
            ST_RX_LO: if (unit_end) begin
                d.rx = {bus_din, q.rx[7:1]};
                d.st = ST_RX_HI;
            end
            ST_RX_HI: if (unit_end) begin
                if (q.bitn == 3'd7) d.st = ST_DONE;
                else begin
                    d.bitn = q.bitn + 1'b1;
                    d.st   = ST_RX_LO;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
        if (powered && !q.pwr) d.shadow = 2'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    always_comb begin
        bus_rw    = (q.st == ST_SETUP) || (q.st == ST_TX_LO) || (q.st == ST_TX_HI);
        bus_doe   = bus_rw;
        bus_clk   = !((q.st == ST_TX_LO) || (q.st == ST_RX_LO));
        bus_dout  = bus_doe && q.sh[0];
        busy      = (q.st != ST_IDLE);
        req_done  = (q.st == ST_DONE);
        req_rdata = q.rx;
    end

    // R13: the completion strobe never lasts two cycles
    assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);
    // R2: a frame opens with the clock high and the driver enabled
    assert_frame_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rw) |-> (bus_clk && bus_doe));
    // R10: an unpowered request finishes at once with the bus left idle
    assert_unpowered_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_start && !powered) |=> (req_done && !bus_rw && bus_clk));
    // R12: once running, busy holds until the done cycle
    assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !req_done) |=> busy);
endmodule

// File: tb/sim_tw_bus_master.sv
`timescale 1ns/1ps
module sim_tw_bus_master;
    localparam int UNIT = 4;
    localparam int PER  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic powered = 1'b1;
    logic req_start = 1'b0;
    logic req_write = 1'b0;
    logic [4:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic req_done, busy, bus_clk, bus_rw, bus_dout, bus_doe;
    logic [7:0] req_rdata;
    logic bus_din = 1'b0;

    int n_checks = 0;
    int n_fail = 0;

    always #(PER/2) clk = ~clk;

    tw_bus_master #(.UNIT_CYCLES(UNIT)) u0 (
        .clk(clk), .rst_n(rst_n), .powered(powered), .req_start(req_start),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_done(req_done), .req_rdata(req_rdata), .busy(busy),
        .bus_clk(bus_clk), .bus_rw(bus_rw), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard of expected frames
    int          exp_n[$];
    logic [15:0] exp_v[$];
    int          tb_bank = 0;
    int          frames_seen = 0;
    logic [7:0]  slave_byte = 8'h00;

    function automatic logic [7:0] model_value(input logic [4:0] a, input logic [7:0] v);
        if (a == 5'h03) return 8'hFF ^ v;
        if (a == 5'h09) return (v < 8'd64) ? 8'(255 - int'(v)) : 8'(191 - int'(v));
        if (a == 5'h12) return v | 8'b0001_0011;
        return v;
    endfunction

    // monitor: rebuild frames from the bus
    int          mon_n = 0;
    logic [15:0] mon_v = '0;
    realtime     t_fall = 0;
    int          rx_i = 0;

    always @(negedge bus_clk) begin
        t_fall = $realtime;
        if (bus_rw === 1'b0) begin
            bus_din = slave_byte[rx_i];
            rx_i++;
        end
    end

    always @(posedge bus_clk) begin
        if (bus_doe === 1'b1) begin
            check(($realtime - t_fall) == UNIT*PER, "R2 low phase length",
                  int'(($realtime - t_fall)/PER), UNIT);
            if (mon_n < 16) mon_v[mon_n] = bus_dout;
            mon_n++;
        end
    end

    always @(negedge bus_rw) begin
        rx_i = 0;
        if (mon_n > 0) begin
            frames_seen++;
            if (exp_n.size() == 0) begin
                check(0, "R12/R10 unexpected frame", int'(mon_v), 0);
            end else begin
                int          en;
                logic [15:0] ev;
                en = exp_n.pop_front();
                ev = exp_v.pop_front();
                check(mon_n == en, "R2/R9 frame bit count", mon_n, en);
                check(mon_v == ev, "R2/R3 frame content", int'(mon_v), int'(ev));
            end
        end
        mon_n = 0;
        mon_v = '0;
    end

    int   n_done = 0;
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (req_done === 1'b1) begin
            n_done++;
            if (prev_done) check(0, "R13 done longer than one cycle", 2, 1);
        end
        prev_done = (req_done === 1'b1);
    end

    task automatic expect_frames(input bit wr, input logic [4:0] a, input logic [7:0] v);
        int bank;
        if (!powered) return;
        bank = a[4] ? 2 : 1;
        if (bank != tb_bank) begin
            exp_n.push_back(16);
            exp_v.push_back({8'h01, 8'(bank)});
            tb_bank = bank;
        end
        if (wr) begin
            exp_n.push_back(16);
            exp_v.push_back({4'h0, a[3:0], model_value(a, v)});
        end else begin
            exp_n.push_back(8);
            exp_v.push_back({8'h00, 4'h0, a[3:0]});
        end
    endtask

    task automatic do_req(input bit wr, input logic [4:0] a, input logic [7:0] v,
                          input bit extra_start, output logic [7:0] rd);
        int d0;
        d0 = n_done;
        expect_frames(wr, a, v);
        @(negedge clk);
        req_start = 1'b1; req_write = wr; req_addr = a; req_wdata = v;
        @(negedge clk);
        if (extra_start) begin
            check(busy == 1'b1, "R12 busy after start", busy, 1);
            req_addr = 5'h07; req_write = 1'b1; req_wdata = 8'h3C;
            @(negedge clk);
        end
        req_start = 1'b0;
        while (req_done !== 1'b1) @(negedge clk);
        rd = req_rdata;
        @(negedge clk);
        check(exp_n.size() == 0, "R3/R4 all expected frames seen", exp_n.size(), 0);
        check(n_done == d0 + 1, "R13 one done per request", n_done - d0, 1);
        while (exp_n.size() > 0) begin
            void'(exp_n.pop_front());
            void'(exp_v.pop_front());
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(PER * 200000);
        check(0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int         f0;
        repeat (3) @(negedge clk);
        check(bus_clk == 1'b1 && bus_rw == 1'b0 && bus_doe == 1'b0, "R1 bus idle in reset",
              {bus_clk, bus_rw, bus_doe}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && req_done == 1'b0, "R1 busy/done low", {busy, req_done}, 0);

        do_req(1, 5'h05, 8'hA5, 0, rd);       // R3 first switch, R8 plain value
        do_req(1, 5'h03, 8'h20, 0, rd);       // R4 same bank, R5 inverted
        do_req(1, 5'h09, 8'h10, 0, rd);       // R6 below split
        do_req(1, 5'h09, 8'h40, 0, rd);       // R6 at split
        do_req(1, 5'h09, 8'hF0, 0, rd);       // R6 wrap
        do_req(1, 5'h12, 8'h40, 0, rd);       // R3 switch to bank 2, R7 forced ones
        do_req(1, 5'h15, 8'h77, 0, rd);       // R4 stay in bank 2, R8

        slave_byte = 8'h96;
        do_req(0, 5'h1D, 8'h00, 0, rd);       // R9 read in bank 2
        check(rd == 8'h96, "R9 read data", rd, 8'h96);
        slave_byte = 8'h0B;
        do_req(0, 5'h00, 8'h00, 0, rd);       // R9 read with switch to bank 1
        check(rd == 8'h0B, "R9 read data after switch", rd, 8'h0B);

        do_req(1, 5'h06, 8'h5A, 1, rd);       // R12 second start ignored

        powered = 1'b0;
        f0 = frames_seen;
        do_req(1, 5'h03, 8'h11, 0, rd);       // R10 silent write
        slave_byte = 8'hFF;
        do_req(0, 5'h0E, 8'h00, 0, rd);       // R10 silent read
        check(rd == 8'h00, "R10 unpowered read returns zero", rd, 0);
        check(frames_seen == f0, "R10 no frames while unpowered", frames_seen - f0, 0);

        @(negedge clk);
        powered = 1'b1;
        tb_bank = 0;                          // R11 power-up forgets the bank
        repeat (2) @(negedge clk);
        do_req(1, 5'h04, 8'h11, 0, rd);       // R11 bank-1 access still switches

        repeat (10) @(negedge clk);
        check(n_done == 13, "R13 total done pulses", n_done, 13);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule